// File: doc/BRIEF.md
# Two-Wire Bus Target Controller

This block is the target (slave) side of a two-wire serial bus, placed in front of a local register interface. It runs entirely in the system clock domain. SCL and SDA are oversampled through synchronizer flops, and START, repeated START and STOP are recognised from the sampled levels. After any START, the block compares the incoming 7-bit address with the programmed one. When the address matches, it takes part in the access by driving SDA through an open-drain enable. In a read access it sends bytes from a transmit holding register. In a write access it captures bytes into a receive holding register.

The CPU side sees the transmit holding register as a valid/ready sink. A byte is accepted on any cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` stays high, a later write replaces the earlier one. `tx_ready` also serves as the transmit-ready flag. It drops when the held byte is copied into the shifter and rises once the master's acknowledge bit for that byte has been sampled.

The receive holding register is a valid/ready source. `rx_valid` stays high and `rx_data` stays stable until `rx_ready` is seen with `rx_valid`. A byte that completes while the register is still full is dropped, and the bus supplies the back-pressure: the byte is not acknowledged. Status levels show whether an access is active (`acc_active`) and its direction (`acc_read`). A sticky end-of-access flag and a sticky overrun flag are both cleared by `flag_clr`.

Top module: `i2c_target`

## Requirements
- R1: After a START or a repeated START, the next eight SCL rising edges carry the address byte, MSB first. Bits 7..1 hold the 7-bit address and bit 0 holds the direction: 1 means the master reads and 0 means the master writes.
- R2: When the address equals `own_addr`, the block pulls SDA low during the ninth SCL pulse (ACK), sets `acc_active`, and sets `acc_read` to the received direction bit.
- R3: When the address differs, SDA is not pulled low on the ninth pulse (NACK) and `acc_active` is 0. Bytes that follow, until the next START, are neither acknowledged nor delivered, and read bits come back as 1.
- R4: A STOP clears `acc_active`. A repeated START followed by a different address clears `acc_active`. A repeated START followed by `own_addr` keeps `acc_active` high and updates `acc_read`.
- R5: `end_of_access` sets in the cycle after `acc_active` falls and stays set until `flag_clr`. A new setting event takes priority over a clear in the same cycle.
- R6: In a read access, each byte is taken from the transmit holding register and sent MSB first. Bytes keep going out while the master ACKs. The last value written while `tx_ready` is high is the one sent.
- R7: `tx_ready` is 1 after reset. It goes to 0 when a byte moves into the shifter and returns to 1 once the master's ACK or NACK for that byte has been sampled.
- R8: A master NACK on a read byte ends transmission for the access: SDA stays released until the next START or STOP.
- R9: In a write access, each received byte is presented on `rx_data` with `rx_valid` and is ACKed. It is held until it is taken with `rx_ready`.
- R10: A byte that completes while `rx_valid` is 1 and `rx_ready` is 0 is dropped and NACKed, and it sets `overrun`. `rx_data` keeps the earlier byte. `flag_clr` clears `overrun`.
- R11: `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R12: After reset: `sda_oe`, `acc_active`, `rx_valid`, `end_of_access` and `overrun` are 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | DW-1 | Programmed target address |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| tx_data | input | DW | Byte for the transmit holding register |
| tx_valid | input | 1 | Write strobe for the transmit holding register |
| tx_ready | output | 1 | Transmit-ready; a write is accepted when high |
| rx_data | output | DW | Receive holding register |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Consumer takes the received byte |
| acc_active | output | 1 | An access to this target is active |
| acc_read | output | 1 | Direction of the access, 1 = master reads |
| end_of_access | output | 1 | Sticky: an access has ended |
| overrun | output | 1 | Sticky: a received byte was dropped |
| flag_clr | input | 1 | Clears end_of_access and overrun |

## Verification
Every bus-driven result comes through SYNC_STAGES synchronizer flops, one edge-detect flop and the protocol register. Each result is therefore due two to four cycles after the pin edge that causes it, and `end_of_access` follows one cycle later than that. The bench holds every SCL phase for 16 cycles. It samples SDA at the end of each high phase, and it checks flags only after a bit or condition task has returned, so each check falls well after its due cycle and before the next bus edge. Holding-register handshakes act on the next clock edge, and the bench checks them on the following falling clock edge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_TXACK,
    ST_RX,
    ST_RXACK,
    ST_WAIT
  } tgt_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic scl;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[STAGES-2:0], d[i]};
    end
    assign q[i] = ff[STAGES-1];
  end

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
  import i2c_tgt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    ev.scl   = scl_s;
    ev.sda   = sda_s;
    ev.rise  = scl_s & ~scl_p;
    ev.fall  = ~scl_s & scl_p;
    ev.start = scl_s & scl_p & sda_p & ~sda_s;
    ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
  end

endmodule

// File: rtl/i2c_tgt_hold.sv
module i2c_tgt_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic          tx_ld,
  input  logic          tx_acked,
  output logic [DW-1:0] hold_q,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_take,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          flag_clr,
  output logic          overrun
);

  logic rx_full;

  assign rx_full = rx_valid & ~rx_ready;
  assign rx_take = rx_push & ~rx_full;

  // transmit side: single holding register plus ready flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ready <= 1'b1;
      hold_q   <= '0;
    end else begin
      if (tx_valid && tx_ready) hold_q <= tx_data;
      if (tx_ld)                tx_ready <= 1'b0;
      else if (tx_acked)        tx_ready <= 1'b1;
    end
  end

  // receive side: single holding register, drop on full
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (rx_take) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_byte;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (rx_push && !rx_take) overrun <= 1'b1;
      else if (flag_clr)       overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_ev_t       ev,
  input  logic [DW-2:0] own_addr,
  input  logic [DW-1:0] hold_q,
  input  logic          rx_take,
  input  logic          flag_clr,
  output logic          sda_oe,
  output logic          acc_active,
  output logic          acc_read,
  output logic          end_of_access,
  output logic          tx_ld,
  output logic          tx_acked,
  output logic          rx_push,
  output logic [DW-1:0] rx_byte
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  tgt_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          hit, mack, rx_ok, act_q;
  logic          addr_eq;

  assign addr_eq = (sh[DW-2:0] == own_addr);
  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      hit        <= 1'b0;
      mack       <= 1'b0;
      sda_oe     <= 1'b0;
      acc_active <= 1'b0;
      acc_read   <= 1'b0;
      tx_ld      <= 1'b0;
      tx_acked   <= 1'b0;
      rx_push    <= 1'b0;
    end else begin
      tx_ld    <= 1'b0;
      tx_acked <= 1'b0;
      rx_push  <= 1'b0;
      if (ev.stop) begin
        state      <= ST_IDLE;
        sda_oe     <= 1'b0;
        acc_active <= 1'b0;
      end else if (ev.start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (ev.rise && cnt < FULL) begin
              sh  <= {sh[DW-2:0], ev.sda};
              cnt <= cnt + 1'b1;
              if (cnt == LAST) begin
                hit        <= addr_eq;
                acc_active <= addr_eq;
                if (addr_eq) acc_read <= ev.sda;
              end
            end else if (ev.fall && cnt == FULL) begin
              if (hit) begin
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_AACK: begin
            if (ev.fall) begin
              cnt <= '0;
              if (acc_read) begin
                sh     <= hold_q;
                sda_oe <= ~hold_q[DW-1];
                tx_ld  <= 1'b1;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (ev.rise) begin
              cnt <= cnt + 1'b1;
            end else if (ev.fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_TXACK;
              end else begin
                sh     <= {sh[DW-2:0], 1'b0};
                sda_oe <= ~sh[DW-2];
              end
            end
          end
          ST_TXACK: begin
            if (ev.rise) begin
              mack     <= ~ev.sda;
              tx_acked <= 1'b1;
            end else if (ev.fall) begin
              cnt <= '0;
              if (mack) begin
                sh     <= hold_q;
                sda_oe <= ~hold_q[DW-1];
                tx_ld  <= 1'b1;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WAIT;
              end
            end
          end
          ST_RX: begin
            if (ev.rise && cnt < FULL) begin
              sh  <= {sh[DW-2:0], ev.sda};
              cnt <= cnt + 1'b1;
              if (cnt == LAST) rx_push <= 1'b1;
            end else if (ev.fall && cnt == FULL) begin
              sda_oe <= rx_ok;
              state  <= ST_RXACK;
            end
          end
          ST_RXACK: begin
            if (ev.fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_RX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // acceptance of the last received byte decides the acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_ok <= 1'b0;
    else if (rx_push) rx_ok <= rx_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q         <= 1'b0;
      end_of_access <= 1'b0;
    end else begin
      act_q <= acc_active;
      if (act_q && !acc_active) end_of_access <= 1'b1;
      else if (flag_clr)        end_of_access <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2c_tgt_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] own_addr,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic          acc_active,
  output logic          acc_read,
  output logic          end_of_access,
  output logic          overrun,
  input  logic          flag_clr
);

  logic [1:0]    pins_s;
  bus_ev_t       ev;
  logic          scl_s, stop_seen;
  logic [DW-1:0] hold_q, rx_byte;
  logic          tx_ld, tx_acked, rx_push, rx_take;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(pins_s)
  );

  i2c_tgt_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(pins_s[1]), .sda_s(pins_s[0]), .ev(ev)
  );

  assign scl_s     = ev.scl;
  assign stop_seen = ev.stop;

  i2c_tgt_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev(ev), .own_addr(own_addr),
    .hold_q(hold_q), .rx_take(rx_take), .flag_clr(flag_clr),
    .sda_oe(sda_oe), .acc_active(acc_active), .acc_read(acc_read),
    .end_of_access(end_of_access), .tx_ld(tx_ld), .tx_acked(tx_acked),
    .rx_push(rx_push), .rx_byte(rx_byte)
  );

  i2c_tgt_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_ld(tx_ld), .tx_acked(tx_acked), .hold_q(hold_q),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_take(rx_take),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .flag_clr(flag_clr), .overrun(overrun)
  );

endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          stop_seen,
  input logic          sda_oe,
  input logic          acc_active,
  input logic          acc_read,
  input logic          end_of_access,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          overrun
);

  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R11

  AST_EOA_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_active) |=> end_of_access); // R5

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !acc_active); // R4

  AST_TXRDY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> (acc_active && acc_read)); // R7

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9

  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_valid)); // R10

endmodule

bind i2c_target i2c_target_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_seen(stop_seen),
  .sda_oe(sda_oe), .acc_active(acc_active), .acc_read(acc_read),
  .end_of_access(end_of_access), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .overrun(overrun)
);

// File: tb/tb_i2c_target.sv
`timescale 1ns/1ps
module tb_i2c_target;

  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus, sda_oe;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;
  logic acc_active, acc_read, end_of_access, overrun, flag_clr = 1'b0;

  int checks = 0, fails = 0, edge_viol = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_target dut (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .acc_active(acc_active), .acc_read(acc_read), .end_of_access(end_of_access),
    .overrun(overrun), .flag_clr(flag_clr)
  );

  // R11 monitor: the enable may only move while the bus clock is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && m_scl) edge_viol++;
    oe_prev <= sda_oe;
  end

  function automatic bit addr_hit(input logic [6:0] a);
    return a == OWN;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; hw();
    m_sda = 1'b0; hw();
    m_scl = 1'b0; hw();
  endtask

  task automatic m_rstart();
    m_sda = 1'b1; hw();
    m_scl = 1'b1; hw();
    m_sda = 1'b0; hw();
    m_scl = 1'b0; hw();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; hw();
    m_scl = 1'b1; hw();
    m_sda = 1'b1; hw();
  endtask

  task automatic m_bit(input bit b, output bit got);
    m_sda = b; hw();
    m_scl = 1'b1; hw();
    got = sda_bus;
    m_scl = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_write(input logic [7:0] d);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rx_pop();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic clr_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    bit g;
    for (int i = 7; i >= 0; i--) m_bit(b[i], g);
    m_bit(1'b1, g);
    ack = !g;
  endtask

  task automatic read_byte(input bit ack, input bit push, input logic [7:0] nxt,
                           output logic [7:0] v);
    bit g;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, g);
      v = {v[6:0], g};
    end
    m_sda = !ack; hw();
    m_scl = 1'b1; repeat (H/2) @(negedge clk);
    chk(tx_ready == 1'b1, "R7 tx_ready back after ack slot", tx_ready, 1);
    if (push) tx_write(nxt);
    repeat (H/2) @(negedge clk);
    m_scl = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    logic [7:0] v;
    logic [6:0] a;
    bit ack, hit, rd;
    int len;
    void'($urandom(32'd4711));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sda_oe == 0 && acc_active == 0 && rx_valid == 0 && end_of_access == 0 &&
        overrun == 0 && tx_ready == 1, "R12 reset state",
        {sda_oe, acc_active, rx_valid, end_of_access, overrun, tx_ready}, 6'b000001);

    // constrained random accesses
    for (int t = 0; t < 24; t++) begin
      a = ($urandom % 4 == 0) ? 7'($urandom % 128) : OWN;
      if (a != OWN && ($urandom % 2 == 0)) a = a;
      hit = addr_hit(a);
      rd  = 1'($urandom % 2);
      len = 1 + int'($urandom % 3);
      for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
      if (rd) tx_write(d[0]);
      m_start();
      write_byte({a, rd}, ack);
      chk(ack == hit, "R1 R2 R3 address acknowledge", ack, hit);
      chk(acc_active == hit, "R2 R3 access active after address", acc_active, hit);
      if (hit) chk(acc_read == rd, "R2 direction flag", acc_read, rd);
      if (!rd) begin
        for (int i = 0; i < (hit ? len : 1); i++) begin
          write_byte(d[i], ack);
          if (hit) begin
            chk(ack == 1, "R9 data byte acked", ack, 1);
            chk(rx_valid == 1 && rx_data == d[i], "R9 received byte", rx_data, d[i]);
            rx_pop();
          end else begin
            chk(ack == 0 && rx_valid == 0, "R3 ignored byte", {ack, rx_valid}, 0);
          end
        end
      end else begin
        for (int i = 0; i < (hit ? len : 1); i++) begin
          read_byte(i != len - 1, i != len - 1, d[(i + 1) % 4], v);
          if (hit) chk(v == d[i], "R6 transmitted byte", v, d[i]);
          else     chk(v == 8'hFF, "R3 released bus on read", v, 8'hFF);
        end
      end
      m_stop();
      chk(acc_active == 0, "R4 stop clears active", acc_active, 0);
      chk(end_of_access == hit, "R5 end of access flag", end_of_access, hit);
      clr_flags();
      chk(end_of_access == 0, "R5 flag clear", end_of_access, 0);
    end

    // R10 overrun: second byte while first unread
    m_start();
    write_byte({OWN, 1'b0}, ack);
    write_byte(8'h3C, ack);
    chk(ack == 1, "R9 first byte acked", ack, 1);
    write_byte(8'hC3, ack);
    chk(ack == 0, "R10 dropped byte nacked", ack, 0);
    chk(overrun == 1 && rx_data == 8'h3C, "R10 overrun keeps old byte", rx_data, 8'h3C);
    clr_flags();
    chk(overrun == 0, "R10 overrun cleared", overrun, 0);
    rx_pop();
    m_stop();
    clr_flags();

    // R6 last write wins, R7 tx_ready low during byte, R8 NACK ends sending
    tx_write(8'h11);
    tx_write(8'h5C);
    m_start();
    write_byte({OWN, 1'b1}, ack);
    repeat (8) @(negedge clk);
    chk(tx_ready == 0, "R7 tx_ready low after load", tx_ready, 0);
    read_byte(1'b0, 1'b0, 8'h00, v);
    chk(v == 8'h5C, "R6 overwrite before load", v, 8'h5C);
    read_byte(1'b0, 1'b0, 8'h00, v);
    chk(v == 8'hFF, "R8 no data after master nack", v, 8'hFF);
    m_stop();
    clr_flags();

    // R4 repeated start: same address keeps active, other address drops it
    m_start();
    write_byte({OWN, 1'b0}, ack);
    write_byte(8'hA5, ack);
    rx_pop();
    tx_write(8'h96);
    m_rstart();
    write_byte({OWN, 1'b1}, ack);
    chk(ack == 1 && acc_active == 1 && acc_read == 1, "R4 rstart same address",
        {ack, acc_active, acc_read}, 3'b111);
    chk(end_of_access == 0, "R5 no end on same-address rstart", end_of_access, 0);
    read_byte(1'b0, 1'b0, 8'h00, v);
    chk(v == 8'h96, "R6 byte after rstart", v, 8'h96);
    m_rstart();
    write_byte({OWN ^ 7'h01, 1'b0}, ack);
    chk(ack == 0 && acc_active == 0, "R4 rstart other address", {ack, acc_active}, 0);
    chk(end_of_access == 1, "R5 end after other-address rstart", end_of_access, 1);
    m_stop();
    clr_flags();

    chk(edge_viol == 0, "R11 sda_oe moved with SCL high", edge_viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule